// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

A synchronous, pipelined static memory of 36-bit words that lets reads and writes alternate on every clock with no idle cycle on the shared data bus. On each rising edge the block samples a word address, three chip selects, a load/advance control, a read/write select, four active-low lane write enables and an active-high freeze input. A load cycle starts a new operation. An advance cycle continues the previous operation at the next address of a four-beat burst, in either XOR (interleaved) or linear order as selected by a static mode pin.

A write gives its address and lane enables in one cycle and its data two active edges later. The write address and enables wait in a two-stage pipeline, so that a read issued in the cycle right after a write still returns the new data: any lane that is about to be written is forwarded. Read data leaves a register two active edges after its address cycle. An asynchronous output enable gates only the bus drive. A doze input stops the block and keeps the stored words. The array is a small parameterised register memory, one slice per lane.

Top module: `zero_turn_sram`

## Requirements
- R1: A load cycle (`new_op_n`=0) selects the block only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other load is a deselect, and its output slot leaves `dout_en` low.
- R2: A selected load with `write_n`=1 is a read. Its word is on `dout`, with `dout_en`=1 when `out_en_n`=0, after the second active edge that follows the address edge.
- R3: A selected load with `write_n`=0 is a write. Data is taken from `din` at the second active edge after the address edge. A low `lane_we_n[i]` writes lane i, which is `din[9*i+8:9*i]`.
- R4: A write with all four `lane_we_n` bits high is an abort and leaves every stored word unchanged.
- R5: In an advance cycle (`new_op_n`=1) the chip selects and `write_n` are ignored, and the previous operation type (read, write or deselect) continues. A deselect followed by advances produces no output data.
- R6: The burst steps only address bits [1:0], and the upper bits stay as loaded. With `order_xor`=1 beat n uses start XOR n. With `order_xor`=0 beat n uses (start + n) mod 4. The sequence wraps after four beats.
- R7: A read issued right after a write to the same word returns the newly written lanes and the stored value of the unwritten lanes.
- R8: An edge with `freeze`=1 is ignored: outputs, burst position and the pipeline hold, and every later data edge moves back by one.
- R9: While `doze`=1, and for the first two edges after it falls, all other inputs are ignored and the stored words are kept. `dout_en` is low while `doze`=1.
- R10: `out_en_n` acts asynchronously and only on `dout_en`. It does not change the pipeline or the data returned.
- R11: After reset `dout_en` is low and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | High: ignore this clock edge |
| doze | input | 1 | Low-power hold, ignores other inputs |
| new_op_n | input | 1 | Low: load a new operation; high: advance burst |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| write_n | input | 1 | Low: write, high: read (load cycles only) |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| addr | input | 6 | Word address |
| order_xor | input | 1 | Burst order: 1 XOR, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data bus |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
On every cycle the assertions check several properties. A frozen edge leaves `dout` unchanged. An unselected load yields an idle pipeline slot. Advance cycles keep the operation type and the upper address bits. A read load across three active edges yields valid read data. `dout_en` stays low while `out_en_n` or `doze` is high. Only the scenarios against the bench's reference model can show the rest: the data values themselves, the XOR and linear beat orders, lane-accurate forwarding to a read right after a write, the abort leaving memory intact, and stored words surviving a doze period.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic               load,
  input  logic [BURST_W-1:0] start,
  input  logic               xor_mode,
  output logic [BURST_W-1:0] cur
);
  logic [BURST_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] step_q, step_d;
  logic [BURST_W-1:0] step_nx;

  always_comb begin
    step_nx = step_q + BURST_W'(1);
    if (load) begin
      cur = start;
    end else if (xor_mode) begin
      cur = base_q ^ step_nx;
    end else begin
      cur = base_q + step_nx;
    end
  end

  always_comb begin
    base_d = base_q;
    step_d = step_q;
    if (step_en) begin
      if (load) begin
        base_d = start;
        step_d = '0;
      end else begin
        step_d = step_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
    end else begin
      base_q <= base_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) begin
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    hit,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] stored,
  input  logic [LANES*LANE_W-1:0] incoming,
  output logic [LANES*LANE_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_mux
    assign merged[g*LANE_W +: LANE_W] = (hit && lane_we[g]) ?
      incoming[g*LANE_W +: LANE_W] : stored[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zero_turn_sram.sv
module zero_turn_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    freeze,
  input  logic                    doze,
  input  logic                    new_op_n,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    write_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order_xor,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int UP_W   = ADDR_W - BURST_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // doze tail: two further edges ignored after doze falls
  logic snz_q1, snz_q2, sleep, act;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      snz_q1 <= 1'b0;
      snz_q2 <= 1'b0;
    end else begin
      snz_q1 <= doze;
      snz_q2 <= snz_q1;
    end
  end

  assign sleep = doze | snz_q1 | snz_q2;
  assign act   = ~freeze & ~sleep;

  // command decode
  logic            sel, load;
  op_e             kind_q, kind_d, kind_n;
  logic [UP_W-1:0] upper_q, upper_d, upper_n;
  logic [BURST_W-1:0] lo;
  logic [ADDR_W-1:0]  acc_addr;

  assign sel  = ~cs0_n & cs1 & ~cs2_n;
  assign load = ~new_op_n;

  always_comb begin
    kind_d  = kind_q;
    upper_d = upper_q;
    if (load) begin
      upper_d = addr[ADDR_W-1:BURST_W];
      if (!sel)         kind_d = OP_NONE;
      else if (write_n) kind_d = OP_READ;
      else              kind_d = OP_WRITE;
    end
    kind_n  = act ? kind_d  : kind_q;
    upper_n = act ? upper_d : upper_q;
  end

  burst_seq #(.BURST_W(BURST_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_en  (act),
    .load     (load),
    .start    (addr[BURST_W-1:0]),
    .xor_mode (order_xor),
    .cur      (lo)
  );

  assign acc_addr = {upper_d, lo};

  // two-stage operation pipeline
  op_e               s1_kind_q, s1_kind_n, s2_kind_q, s2_kind_n;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_n, s2_addr_q, s2_addr_n;
  logic [LANES-1:0]  s1_we_q, s1_we_n, s2_we_q, s2_we_n;

  always_comb begin
    s1_kind_n = s1_kind_q;
    s1_addr_n = s1_addr_q;
    s1_we_n   = s1_we_q;
    s2_kind_n = s2_kind_q;
    s2_addr_n = s2_addr_q;
    s2_we_n   = s2_we_q;
    if (act) begin
      s1_kind_n = kind_d;
      s1_addr_n = acc_addr;
      s1_we_n   = ~lane_we_n;
      s2_kind_n = s1_kind_q;
      s2_addr_n = s1_addr_q;
      s2_we_n   = s1_we_q;
    end
  end

  // array, forwarding and read registers
  logic [DATA_W-1:0] arr_rd, merged;
  logic [DATA_W-1:0] rbuf_q, rbuf_n, q_data_q, q_data_n;
  logic              rbuf_vld_q, rbuf_vld_n, q_vld_q, q_vld_n;
  logic              arr_we, hit;

  assign arr_we = act && (s2_kind_q == OP_WRITE);
  assign hit    = (s2_kind_q == OP_WRITE) && (s2_addr_q == s1_addr_q);

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (arr_we),
    .wr_addr (s2_addr_q),
    .lane_we (s2_we_q),
    .wr_data (din),
    .rd_addr (s1_addr_q),
    .rd_data (arr_rd)
  );

  lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .hit      (hit),
    .lane_we  (s2_we_q),
    .stored   (arr_rd),
    .incoming (din),
    .merged   (merged)
  );

  always_comb begin
    rbuf_n     = rbuf_q;
    rbuf_vld_n = rbuf_vld_q;
    q_data_n   = q_data_q;
    q_vld_n    = q_vld_q;
    if (act) begin
      rbuf_vld_n = (s1_kind_q == OP_READ);
      if (s1_kind_q == OP_READ) rbuf_n = merged;
      q_vld_n    = rbuf_vld_q;
      q_data_n   = rbuf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kind_q     <= OP_NONE;
      upper_q    <= '0;
      s1_kind_q  <= OP_NONE;
      s1_addr_q  <= '0;
      s1_we_q    <= '0;
      s2_kind_q  <= OP_NONE;
      s2_addr_q  <= '0;
      s2_we_q    <= '0;
      rbuf_q     <= '0;
      rbuf_vld_q <= 1'b0;
      q_data_q   <= '0;
      q_vld_q    <= 1'b0;
    end else begin
      kind_q     <= kind_n;
      upper_q    <= upper_n;
      s1_kind_q  <= s1_kind_n;
      s1_addr_q  <= s1_addr_n;
      s1_we_q    <= s1_we_n;
      s2_kind_q  <= s2_kind_n;
      s2_addr_q  <= s2_addr_n;
      s2_we_q    <= s2_we_n;
      rbuf_q     <= rbuf_n;
      rbuf_vld_q <= rbuf_vld_n;
      q_data_q   <= q_data_n;
      q_vld_q    <= q_vld_n;
    end
  end

  assign dout    = q_data_q;
  assign dout_en = q_vld_q & ~out_en_n & ~doze;
endmodule

// File: rtl/sram_chk.sv
module sram_chk
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int DATA_W  = 36
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              freeze,
  input logic              doze,
  input logic              tail1,
  input logic              tail2,
  input logic              new_op_n,
  input logic              cs0_n,
  input logic              cs1,
  input logic              cs2_n,
  input logic              write_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input op_e               s1_kind,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              q_vld
);
  logic act_c, sel_c;
  assign act_c = !freeze && !(doze || tail1 || tail2);
  assign sel_c = !cs0_n && cs1 && !cs2_n;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    freeze |=> $stable(dout));

  // R9
  doze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    doze |-> !dout_en);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_en_n |-> !dout_en);

  // R1
  desel_slot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_c && !new_op_n && !sel_c) |=> (s1_kind == OP_NONE));

  // R5
  kind_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_c && new_op_n) |=> (s1_kind == $past(s1_kind)));

  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_c && new_op_n) |=>
      (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_c && !new_op_n && sel_c && write_n) ##1 act_c ##1 act_c |=> q_vld);
endmodule

bind zero_turn_sram sram_chk #(
  .ADDR_W  (ADDR_W),
  .BURST_W (BURST_W),
  .DATA_W  (LANES * LANE_W)
) u_sram_chk (
  .clk       (clk),
  .rst_int_n (rst_sync_n),
  .freeze    (freeze),
  .doze      (doze),
  .tail1     (snz_q1),
  .tail2     (snz_q2),
  .new_op_n  (new_op_n),
  .cs0_n     (cs0_n),
  .cs1       (cs1),
  .cs2_n     (cs2_n),
  .write_n   (write_n),
  .out_en_n  (out_en_n),
  .dout      (dout),
  .dout_en   (dout_en),
  .s1_kind   (s1_kind_q),
  .s1_addr   (s1_addr_q),
  .q_vld     (q_vld_q)
);

// File: tb/test_zero_turn_sram.sv
module test_zero_turn_sram;
  logic        clk, rst_n, freeze, doze, new_op_n, cs0_n, cs1, cs2_n, write_n;
  logic [3:0]  lane_we_n;
  logic [5:0]  addr;
  logic        order_xor, out_en_n;
  logic [35:0] din, dout;
  logic        dout_en;

  zero_turn_sram i_zero_turn_sram (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .doze(doze),
    .new_op_n(new_op_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .write_n(write_n), .lane_we_n(lane_we_n), .addr(addr),
    .order_xor(order_xor), .out_en_n(out_en_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string req    = "R2/R3";

  task automatic chk(input logic ok, input string tag, input logic [35:0] act_v,
                     input logic [35:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic logic [35:0] mk(input int i);
    return (36'(i + 1) * 36'h0_0F0E_0D0B) ^ 36'h9_8765_4321;
  endfunction

  // behavioural reference model
  typedef struct {
    int          kind;   // 0 none, 1 read, 2 write
    int          adr;
    logic [3:0]  we;
    logic [35:0] dat;
    int          age;
  } ent_t;

  ent_t        pq[$];
  logic [35:0] mm [64];
  logic [35:0] seen[$];
  logic [35:0] nx_data = '0;
  logic [35:0] exp_data = '0;
  logic        exp_vld = 1'b0;
  logic        fresh = 1'b0;
  int          mkind = 0, mbase = 0, mstep = 0;
  logic        mt1 = 1'b0, mt2 = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq.delete();
      exp_vld = 1'b0; mkind = 0; mbase = 0; mstep = 0; mt1 = 1'b0; mt2 = 1'b0;
      fresh = 1'b0;
    end else begin
      logic slp;
      slp = doze | mt1 | mt2;
      mt2 = mt1;
      mt1 = doze;
      fresh = 1'b0;
      if (!freeze && !slp) begin
        int cur;
        ent_t e;
        foreach (pq[i]) pq[i].age++;
        if (pq.size() > 0 && pq[0].age == 2) begin
          e = pq.pop_front();
          if (e.kind == 2) begin
            for (int l = 0; l < 4; l++)
              if (e.we[l]) mm[e.adr][l*9 +: 9] = din[l*9 +: 9];
            exp_vld = 1'b0;
          end else if (e.kind == 1) begin
            exp_vld = 1'b1;
            exp_data = mm[e.adr];
            fresh = 1'b1;
          end else begin
            exp_vld = 1'b0;
          end
        end
        if (!new_op_n) begin
          if (!cs0_n && cs1 && !cs2_n) mkind = write_n ? 1 : 2;
          else mkind = 0;
          mbase = int'(addr);
          mstep = 0;
          cur = mbase;
        end else begin
          int lo;
          mstep = (mstep + 1) % 4;
          lo = order_xor ? ((mbase % 4) ^ mstep) : (((mbase % 4) + mstep) % 4);
          cur = (mbase / 4) * 4 + lo;
        end
        e.kind = mkind; e.adr = cur; e.we = ~lane_we_n; e.dat = nx_data; e.age = 0;
        pq.push_back(e);
      end
      #5;
      begin
        logic exp_en;
        exp_en = exp_vld && !out_en_n && !doze;
        chk(dout_en === exp_en, {req, " dout_en"}, 36'(dout_en), 36'(exp_en));
        if (exp_en) chk(dout === exp_data, {req, " dout"}, dout, exp_data);
        if (fresh && dout_en) seen.push_back(dout);
      end
    end
  end

  // data bus: present a write's data before its data edge
  always @(negedge clk) begin
    logic [35:0] v;
    v = 36'hA_5A5A_5A5A;
    foreach (pq[i]) if (pq[i].age == 1 && pq[i].kind == 2) v = pq[i].dat;
    din = v;
  end

  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] DES = 3'b110;

  task automatic step(input logic ld_n, input logic [2:0] cs, input logic wn,
                      input logic [3:0] ben, input int a, input logic [35:0] d);
    @(negedge clk);
    freeze = 1'b0;
    new_op_n = ld_n; {cs0_n, cs1, cs2_n} = cs; write_n = wn;
    lane_we_n = ben; addr = 6'(a); nx_data = d;
  endtask

  task automatic wr(input int a, input logic [35:0] d);
    step(1'b0, SEL, 1'b0, 4'h0, a, d);
  endtask
  task automatic rd(input int a);
    step(1'b0, SEL, 1'b1, 4'hF, a, '0);
  endtask
  task automatic adv();
    step(1'b1, DES, 1'b0, 4'hF, 0, '0);
  endtask
  task automatic drain();
    repeat (4) step(1'b0, DES, 1'b1, 4'hF, 0, '0);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; freeze = 1'b0; doze = 1'b0; new_op_n = 1'b0;
    {cs0_n, cs1, cs2_n} = DES; write_n = 1'b1; lane_we_n = 4'hF; addr = '0;
    order_xor = 1'b1; out_en_n = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, DES, 1'b1, 4'hF, 0, '0);
    // R11 reset state
    chk(dout_en === 1'b0, "R11 reset dout_en", 36'(dout_en), 36'd0);

    // R3 fill every word with full-width writes
    req = "R3";
    for (int i = 0; i < 64; i++) wr(i, mk(i));
    drain();

    // R7 read straight after write, full and partial lanes
    req = "R7"; seen.delete();
    begin
      logic [35:0] y, pm;
      y = 36'h1_2345_6789;
      wr(20, 36'hC_0FFE_E123);
      rd(20);
      step(1'b0, SEL, 1'b0, 4'b1010, 21, y);
      rd(21);
      drain();
      pm = mk(21);
      pm[8:0] = y[8:0];
      pm[26:18] = y[26:18];
      chk(seen.size() == 2, "R7 count", 36'(seen.size()), 36'd2);
      if (seen.size() == 2) begin
        chk(seen[0] === 36'hC_0FFE_E123, "R7 full forward", seen[0], 36'hC_0FFE_E123);
        chk(seen[1] === pm, "R7 lane merge", seen[1], pm);
      end
    end

    // R4 write abort
    req = "R4"; seen.delete();
    step(1'b0, SEL, 1'b0, 4'hF, 5, 36'h0_DEAD_0BAD);
    rd(5);
    drain();
    chk(seen.size() == 1 && seen[0] === mk(5), "R4 abort", seen[0], mk(5));

    // R1 / R5 deselect then advances yields nothing
    req = "R5"; seen.delete();
    step(1'b0, 3'b011, 1'b1, 4'hF, 8, '0);
    adv(); adv(); adv();
    step(1'b0, 3'b000, 1'b1, 4'hF, 8, '0);
    drain();
    chk(seen.size() == 0, "R1 deselect no data", 36'(seen.size()), 36'd0);

    // R6 XOR order from start 9
    req = "R6"; seen.delete();
    order_xor = 1'b1;
    rd(9); adv(); adv(); adv();
    drain();
    chk(seen.size() == 4, "R6 xor count", 36'(seen.size()), 36'd4);
    if (seen.size() == 4) begin
      chk(seen[1] === mk(8), "R6 xor beat1", seen[1], mk(8));
      chk(seen[2] === mk(11), "R6 xor beat2", seen[2], mk(11));
      chk(seen[3] === mk(10), "R6 xor beat3", seen[3], mk(10));
    end

    // R6 linear order from start 9
    seen.delete();
    order_xor = 1'b0;
    rd(9); adv(); adv(); adv(); adv();
    drain();
    chk(seen.size() == 5, "R6 lin count", 36'(seen.size()), 36'd5);
    if (seen.size() == 5) begin
      chk(seen[1] === mk(10), "R6 lin beat1", seen[1], mk(10));
      chk(seen[3] === mk(8), "R6 lin beat3", seen[3], mk(8));
      chk(seen[4] === mk(9), "R6 lin wrap", seen[4], mk(9));
    end

    // R5 write burst continues with write_n high
    req = "R5"; seen.delete();
    wr(40, 36'h4_0000_0040);
    step(1'b1, SEL, 1'b1, 4'h0, 0, 36'h4_0000_0041);
    step(1'b1, SEL, 1'b1, 4'h0, 0, 36'h4_0000_0042);
    rd(41);
    drain();
    chk(seen.size() == 1 && seen[0] === 36'h4_0000_0041, "R5 write continues",
        seen[0], 36'h4_0000_0041);

    // R8 freeze in the middle of a linear burst
    req = "R8"; seen.delete();
    rd(12); adv();
    @(negedge clk);
    freeze = 1'b1; new_op_n = 1'b0; {cs0_n, cs1, cs2_n} = SEL; write_n = 1'b0;
    @(negedge clk);
    adv(); adv();
    drain();
    chk(seen.size() == 4, "R8 count", 36'(seen.size()), 36'd4);
    if (seen.size() == 4) begin
      chk(seen[2] === mk(14), "R8 beat2 after stall", seen[2], mk(14));
      chk(seen[3] === mk(15), "R8 beat3 after stall", seen[3], mk(15));
    end

    // R9 doze ignores writes and keeps contents
    req = "R9"; seen.delete();
    @(negedge clk);
    doze = 1'b1; new_op_n = 1'b0; {cs0_n, cs1, cs2_n} = SEL; write_n = 1'b0;
    lane_we_n = 4'h0; addr = 6'd0;
    repeat (3) @(negedge clk);
    doze = 1'b0; addr = 6'd1;
    @(negedge clk);
    chk(dout_en === 1'b0, "R9 quiet after doze", 36'(dout_en), 36'd0);
    rd(0); rd(1);
    drain();
    chk(seen.size() == 2, "R9 count", 36'(seen.size()), 36'd2);
    if (seen.size() == 2) begin
      chk(seen[0] === mk(0), "R9 word0 kept", seen[0], mk(0));
      chk(seen[1] === mk(1), "R9 word1 kept", seen[1], mk(1));
    end

    // R10 asynchronous output enable
    req = "R10"; seen.delete();
    rd(31);
    step(1'b0, DES, 1'b1, 4'hF, 0, '0);
    step(1'b0, DES, 1'b1, 4'hF, 0, '0);
    @(negedge clk);
    freeze = 1'b1;
    #2 out_en_n = 1'b1;
    #1 chk(dout_en === 1'b0, "R10 oe high", 36'(dout_en), 36'd0);
    #1 out_en_n = 1'b0;
    #1 chk(dout_en === 1'b1 && dout === mk(31), "R10 oe low", dout, mk(31));
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule